// File: doc/BRIEF.md
# Load-Dependent High-Side On-Time Ceiling

This block sits between a PWM modulator and the high-side gate command of a switching regulator phase. Every switching period it grants the modulator's on-request only up to a ceiling, so that each cycle keeps enough off-time for current reading and phase balancing. The ceiling is not a fixed duty clamp. It falls linearly with a digitised per-phase current-sense code, from 80% of the period at zero current to 40% of the period at the full-scale code.

The limit is computed in clock cycles once per period, when the period-start strobe arrives. It uses the programmed period length and the current code present at that moment, with integer arithmetic rounded down. An on-time counter counts granted cycles. Once the count reaches the limit, the gate output stays low for the rest of the period, even if the request stays high. The pulse is never stretched to make up for a sagging output. A one-clock flag marks the cycle in which the ceiling cut a pulse short.

Top module: `ontime_ceiling`

## Requirements
- R1: Under synchronous reset, `hs_gate` and `limit_hit` are low and the on-time count and captured limit are zero. After reset and before the first `period_start`, the limit is zero, so `hs_gate` stays low whatever `pwm_req` does.
- R2: At each clock edge where `period_start` is high, the limit in cycles becomes floor(P*(4*F - 2*c)/(5*F)). Here P is `period_len`, F is the full-scale code (default 200) and c is the code at that edge. This gives floor(0.8*P) for c = 0 and floor(0.4*P) for c = F.
- R3: Within one period, the number of cycles with `hs_gate` high never exceeds that period's limit, whatever the request pattern.
- R4: A code above F gives the same limit as c = F.
- R5: Changes to `isense_code` or `period_len` between two period starts do not change the running period's limit.
- R6: `hs_gate` is registered. After an edge it is high exactly when `pwm_req` was high at that edge and the on-time count (zeroed at a period start) was below the limit.
- R7: The on-time count advances only in granted cycles and holds while `pwm_req` is low. A request that re-asserts in the same period resumes against the remaining budget.
- R8: `limit_hit` is high for one clock, in the cycle where `hs_gate` falls because the limit was reached while `pwm_req` was still high. It stays low when the request itself ends the pulse.
- R9: Once the limit is reached, `hs_gate` stays low until the next `period_start`, even if `pwm_req` stays high.
- R10: `period_start` zeroes the count. A request held across the period boundary stays granted into the new period if the new limit is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-clock strobe opening a switching period |
| period_len | input | PER_W | Switching period length in clock cycles |
| pwm_req | input | 1 | Raw high-side request from the modulator |
| isense_code | input | CODE_W | Unsigned per-phase current-sense code |
| hs_gate | output | 1 | Gated high-side command |
| limit_hit | output | 1 | One-clock pulse when the ceiling truncated a pulse |

## Verification
The bench targets the following corner cases:
- **Both ends of the line and the saturated region.** A wrong slope, an inverted sign or a missing clamp would give a visibly wrong count of granted cycles in a held-request period.
- **A limit that rounds down to zero.** An off-by-one comparator would leak a single high cycle here.
- **A request that drops and re-asserts inside a period.** A counter that restarts instead of holding would grant more than the budget.
- **Code and period-length changes in mid-period.** A design that recomputes the limit continuously would move the cut point.
- **A request held across a period boundary.** A design that fails to clear the count would stay low.
- **Flag timing.** The bench checks that `limit_hit` coincides with the falling `hs_gate` and does not fire when the request ends the pulse on its own.

// File: rtl/ontime_pkg.sv
package ontime_pkg;
  // Ceiling ratios: HI/DEN of the period at zero current, LO/DEN at full scale.
  localparam int ONT_HI_NUM = 4;
  localparam int ONT_LO_NUM = 2;
  localparam int ONT_DEN    = 5;
  localparam int ONT_SLOPE  = ONT_HI_NUM - ONT_LO_NUM;
endpackage

// File: rtl/ontime_limit_calc.sv
module ontime_limit_calc
  import ontime_pkg::*;
#(
  parameter int PER_W      = 12,
  parameter int CODE_W     = 8,
  parameter int FULL_SCALE = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_start,
  input  logic [PER_W-1:0]  period_len,
  input  logic [CODE_W-1:0] isense_code,
  output logic [PER_W-1:0]  lim_next,
  output logic [PER_W-1:0]  lim_q
);
  localparam int MULT_W = $clog2(ONT_HI_NUM * FULL_SCALE + 1);
  localparam int PROD_W = PER_W + MULT_W;
  localparam logic [CODE_W-1:0] FS_CODE = CODE_W'(FULL_SCALE);
  localparam logic [MULT_W-1:0] TOP_MULT = MULT_W'(ONT_HI_NUM * FULL_SCALE);
  localparam logic [MULT_W-1:0] SLOPE_M  = MULT_W'(ONT_SLOPE);
  localparam logic [PROD_W-1:0] DIVISOR  = PROD_W'(ONT_DEN * FULL_SCALE);

  logic [CODE_W-1:0] code_sat;
  logic [MULT_W-1:0] mult;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    code_sat = (isense_code > FS_CODE) ? FS_CODE : isense_code;
    mult     = TOP_MULT - (MULT_W'(code_sat) * SLOPE_M);
    prod     = PROD_W'(period_len) * PROD_W'(mult);
    quot     = prod / DIVISOR;
    lim_next = quot[PER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
    end else if (period_start) begin
      lim_q <= lim_next;
    end
  end

  AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(lim_q)); // R5

  AST_LIM_BAND: assert property (@(posedge clk) disable iff (rst)
    period_start |=>
      (int'(lim_q) * ONT_DEN <= int'($past(period_len)) * ONT_HI_NUM) &&
      (int'(lim_q) * ONT_DEN + ONT_DEN > int'($past(period_len)) * ONT_LO_NUM)); // R2
endmodule

// File: rtl/ontime_gate.sv
module ontime_gate #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_start,
  input  logic             pwm_req,
  input  logic [PER_W-1:0] lim_use,
  output logic [PER_W-1:0] on_cnt,
  output logic             hs_q,
  output logic             trunc_q
);
  logic [PER_W-1:0] cnt_base;
  logic             grant;

  always_comb begin
    cnt_base = period_start ? '0 : on_cnt;
    grant    = pwm_req && (cnt_base < lim_use);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_cnt  <= '0;
      hs_q    <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      on_cnt  <= cnt_base + PER_W'(grant);
      hs_q    <= grant;
      trunc_q <= pwm_req && !grant && hs_q;
    end
  end

  AST_TRUNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trunc_q |=> !trunc_q); // R8

  AST_TRUNC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    trunc_q |-> (!hs_q && $past(pwm_req))); // R8

  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (trunc_q && !period_start) |=> !hs_q); // R9
endmodule

// File: rtl/ontime_ceiling.sv
module ontime_ceiling #(
  parameter int PER_W      = 12,
  parameter int CODE_W     = 8,
  parameter int FULL_SCALE = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_start,
  input  logic [PER_W-1:0]  period_len,
  input  logic              pwm_req,
  input  logic [CODE_W-1:0] isense_code,
  output logic              hs_gate,
  output logic              limit_hit
);
  logic [PER_W-1:0] lim_next;
  logic [PER_W-1:0] lim_q;
  logic [PER_W-1:0] lim_use;
  logic [PER_W-1:0] on_cnt;

  ontime_limit_calc #(
    .PER_W(PER_W), .CODE_W(CODE_W), .FULL_SCALE(FULL_SCALE)
  ) u_calc (
    .clk(clk), .rst(rst), .period_start(period_start),
    .period_len(period_len), .isense_code(isense_code),
    .lim_next(lim_next), .lim_q(lim_q)
  );

  assign lim_use = period_start ? lim_next : lim_q;

  ontime_gate #(.PER_W(PER_W)) u_gate (
    .clk(clk), .rst(rst), .period_start(period_start), .pwm_req(pwm_req),
    .lim_use(lim_use), .on_cnt(on_cnt), .hs_q(hs_gate), .trunc_q(limit_hit)
  );

  AST_HS_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    hs_gate |-> $past(pwm_req)); // R6

  AST_CNT_WITHIN_LIM: assert property (@(posedge clk) disable iff (rst)
    on_cnt <= lim_q); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!hs_gate && !limit_hit && on_cnt == '0)); // R1
endmodule

// File: tb/ontime_ceiling_bench.sv
`timescale 1ns/1ps
module ontime_ceiling_bench;
  localparam int PER_W  = 12;
  localparam int CODE_W = 8;
  localparam int FS     = 200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              period_start = 1'b0;
  logic [PER_W-1:0]  period_len = '0;
  logic              pwm_req = 1'b0;
  logic [CODE_W-1:0] isense_code = '0;
  logic              hs_gate;
  logic              limit_hit;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int  m_lim = 0;
  int  m_cnt = 0;
  bit  m_hs = 0;
  bit  m_trunc = 0;
  int  seen_on = 0;
  int  seen_hits = 0;

  always #2.5 clk = ~clk;

  ontime_ceiling #(.PER_W(PER_W), .CODE_W(CODE_W), .FULL_SCALE(FS)) u_ontime_ceiling (
    .clk(clk), .rst(rst), .period_start(period_start), .period_len(period_len),
    .pwm_req(pwm_req), .isense_code(isense_code),
    .hs_gate(hs_gate), .limit_hit(limit_hit)
  );

  function automatic int lim_of(input int plen, input int code);
    int c;
    c = (code > FS) ? FS : code;
    return (plen * (4 * FS - 2 * c)) / (5 * FS);
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, advance the reference, compare after the edge.
  task automatic step(input bit ps, input bit req, input int code, input int plen,
                      input string tag);
    int base;
    int lu;
    bit grant;
    period_start = ps;
    pwm_req      = req;
    isense_code  = CODE_W'(code);
    period_len   = PER_W'(plen);
    lu = ps ? lim_of(plen, code) : m_lim;
    if (ps) m_lim = lu;
    base    = ps ? 0 : m_cnt;
    grant   = req && (base < lu);
    m_trunc = req && !grant && m_hs;
    m_hs    = grant;
    m_cnt   = base + (grant ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    check(hs_gate == m_hs, tag, "hs_gate", int'(hs_gate), int'(m_hs));
    check(limit_hit == m_trunc, "R8", "limit_hit", int'(limit_hit), int'(m_trunc));
    if (hs_gate) seen_on++;
    if (limit_hit) seen_hits++;
  endtask

  // Full period with the request held high; checks the granted cycle count.
  task automatic held_period(input int plen, input int code, input int exp_on,
                             input string tag);
    seen_on = 0;
    seen_hits = 0;
    for (int i = 0; i < plen; i++) step(i == 0, 1'b1, code, plen, tag);
    check(seen_on == exp_on, tag, "granted cycles", seen_on, exp_on);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int plen;
    int code;
    int mode;
    int cut;
    bit req;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(hs_gate == 1'b0, "R1", "hs_gate in reset", int'(hs_gate), 0);
    check(limit_hit == 1'b0, "R1", "limit_hit in reset", int'(limit_hit), 0);
    rst = 1'b0;
    // R1: request without any period start: limit is zero
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 0, 100, "R1");

    // R2: ends and middle of the line
    held_period(100, 0, 80, "R2");
    held_period(100, FS, 40, "R2");
    held_period(100, 100, 60, "R2");
    held_period(37, 55, lim_of(37, 55), "R2");
    // R4: saturation above full scale
    held_period(100, 255, 40, "R4");
    held_period(100, FS + 1, 40, "R4");
    // R3: limit that rounds to zero grants nothing
    held_period(2, FS, 0, "R3");

    // R7: request drops and comes back inside the period; budget 40 in total
    seen_on = 0;
    for (int i = 0; i < 100; i++)
      step(i == 0, (i < 15) || (i >= 30), FS, 100, "R7");
    check(seen_on == 40, "R7", "resumed budget", seen_on, 40);

    // R8: request ends before the limit; no flag expected
    seen_hits = 0;
    for (int i = 0; i < 50; i++) step(i == 0, i < 10, 0, 50, "R8");
    check(seen_hits == 0, "R8", "flag on natural end", seen_hits, 0);

    // R5: code and length move mid-period; limit set at start (P=100,c=0 -> 80)
    seen_on = 0;
    for (int i = 0; i < 100; i++)
      step(i == 0, 1'b1, (i == 0) ? 0 : 255, (i == 0) ? 100 : 20, "R5");
    check(seen_on == 80, "R5", "mid-period changes ignored", seen_on, 80);

    // R10: request held across boundary; R9: stays low after the cut
    seen_on = 0;
    for (int i = 0; i < 10; i++) step(i == 0, 1'b1, 0, 10, "R9");
    for (int i = 0; i < 10; i++) step(i == 0, 1'b1, 0, 10, "R10");
    check(seen_on == 16, "R10", "two held periods", seen_on, 16);

    // Random periods
    for (int p = 0; p < 300; p++) begin
      plen = 4 + int'($urandom % 117);
      code = int'($urandom % 256);
      mode = int'($urandom % 3);
      cut  = int'($urandom % plen);
      seen_on = 0;
      for (int i = 0; i < plen; i++) begin
        case (mode)
          0: req = 1'b1;
          1: req = ($urandom % 4) != 0;
          default: req = i < cut;
        endcase
        step(i == 0, req, (i == 0) ? code : int'($urandom % 256),
             (i == 0) ? plen : 4 + int'($urandom % 117), "R6");
      end
      check(seen_on <= lim_of(plen, code), "R3", "period on-cycles", seen_on,
            lim_of(plen, code));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule